// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer for an 8-bit Core

This block sits beside the control unit of a small accumulator processor with a 16-bit address space. At every instruction end it decides whether the core must leave its program: a reset request, a non-maskable interrupt, a maskable interrupt, or a software break requested by the ending instruction. It then owns the byte-wide memory port for a few cycles. It saves the return address and the status byte on the stack in page one, reads a two-byte handler address and hands the new program counter, status and stack pointer back to the core in one load strobe.

The same engine runs the return-from-interrupt tail. When the ending instruction asks for it, the block reads the status byte and the two address bytes back from the stack and restores them. The core keeps its program counter, status and stack pointer inputs stable while `busy` is high. It raises `insn_end` during the last cycle of each instruction, with `op_brk` or `op_rti` alongside it when that instruction is a break or a return.

Top module: `irq_entry_seq`

## Requirements
- R1: A reset (release of `rst_n`, or `reset_req` high with `insn_end`) reads 0xFFFC, then 0xFFFD. It then loads the program counter as {byte from 0xFFFD, byte from 0xFFFC}, with status = `p_in` with bit 2 set and the stack pointer unchanged. It makes no memory writes, and it discards a pending non-maskable request.
- R2: An interrupt or break entry makes three writes. The first puts pc[15:8] at 0x0100+sp, the second puts pc[7:0] at 0x0100+sp-1, and the third puts the status byte at 0x0100+sp-2. The stack pointer is then loaded with sp-3.
- R3: The pushed status has bit 5 set and has bit 4 (break) set for a break and clear for hardware interrupts. All other bits are copied from `p_in`.
- R4: Handler addresses are read low byte first. The non-maskable request uses 0xFFFA/0xFFFB, and both the maskable request and the break use 0xFFFE/0xFFFF.
- R5: A low `irq_n` is served only when status bit 2 (interrupt disable) is clear. A non-maskable request is served whatever that bit holds.
- R6: Every entry (reset, non-maskable, maskable, break) loads status with bit 2 set.
- R7: Each falling edge of `nmi_n` is latched until served and is served once. Holding `nmi_n` low does not cause a second entry.
- R8: Order at one instruction end: reset first, then the ending instruction's own break or return, then the non-maskable request, then the maskable one. A hardware request that loses waits for the next instruction end.
- R9: A request must be present at the clock edge that closes the penultimate cycle of an instruction to be served at its end. A request that first appears in the last cycle is served at the end of the following instruction.
- R10: A return reads status from 0x0100+sp+1, the low address byte from sp+2 and the high byte from sp+3. It then loads the program counter, the status byte exactly as read, and sp+3.
- R11: `busy` is high from the start of a sequence until the cycle after the load strobe, and `insn_end` is not acted on while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_end | input | 1 | High in the last cycle of an instruction |
| op_brk | input | 1 | Ending instruction is a software break |
| op_rti | input | 1 | Ending instruction is a return from interrupt |
| reset_req | input | 1 | Warm reset request, acted on at an instruction end |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| pc_in | input | 16 | Core program counter (return address) |
| p_in | input | 8 | Core status byte |
| sp_in | input | 8 | Core stack pointer |
| load_ctx | output | 1 | Strobe: core loads pc_out, p_out, sp_out |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status byte |
| sp_out | output | 8 | New stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle the read is issued |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest situations to reach are the ones where timing and precedence collide. One is a maskable request that appears exactly in the last cycle of an instruction and must slip by one instruction. Another is a non-maskable edge that arrives together with a break and must survive the break entry to be served at the next boundary. The stimulus places each edge of `irq_n` and `nmi_n` at a chosen cycle index inside a modelled instruction. A scoreboard holds the expected bus and load events, so a slip or a lost request shows up as an extra, missing or reordered event.

// File: rtl/intseq_pkg.sv
package intseq_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] STACK_PAGE = 8'h01;
  localparam int I_POS = 2;
  localparam int B_POS = 4;
  localparam int U_POS = 5;
  localparam logic [AW-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [AW-1:0] VEC_RST = 16'hFFFC;
  localparam logic [AW-1:0] VEC_IRQ = 16'hFFFE;
  localparam int ENTRY_PUSHES = 3;

  typedef enum logic [2:0] {K_RST, K_NMI, K_IRQ, K_BRK, K_RTI} kind_e;

  typedef enum logic [3:0] {
    S_BOOT, S_IDLE, S_PUSH_H, S_PUSH_L, S_PUSH_P,
    S_VEC_L, S_VEC_H, S_PULL_P, S_PULL_L, S_PULL_H
  } state_e;
endpackage

// File: rtl/intseq_sampler.sv
module intseq_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic nmi_ack,
  input  logic nmi_clr,
  output logic nmi_pend,
  output logic irq_lvl
);
  logic nmi_d;
  logic nmi_fall;
  logic pend_nx;

  always_comb begin
    nmi_fall = nmi_d & ~nmi_n;
    pend_nx  = nmi_fall | (nmi_pend & ~nmi_ack & ~nmi_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d    <= 1'b1;
      nmi_pend <= 1'b0;
      irq_lvl  <= 1'b0;
    end else begin
      nmi_d    <= nmi_n;
      nmi_pend <= pend_nx;
      irq_lvl  <= ~irq_n;
    end
  end

  // R7: a served request leaves nothing pending unless a fresh edge arrived
  assert_nmi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && !(nmi_d && !nmi_n)) |=> !nmi_pend);

  // R7: a pending request does not vanish without being served or cleared
  assert_nmi_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_ack && !nmi_clr) |=> nmi_pend);
endmodule

// File: rtl/intseq_arbiter.sv
module intseq_arbiter
  import intseq_pkg::*;
(
  input  logic  idle,
  input  logic  insn_end,
  input  logic  reset_req,
  input  logic  op_brk,
  input  logic  op_rti,
  input  logic  nmi_pend,
  input  logic  irq_lvl,
  input  logic  i_flag,
  output logic  start,
  output kind_e kind
);
  logic irq_ok;

  always_comb begin
    irq_ok = irq_lvl & ~i_flag;
    start  = idle & insn_end & (reset_req | op_brk | op_rti | nmi_pend | irq_ok);
    if (reset_req)     kind = K_RST;
    else if (op_rti)   kind = K_RTI;
    else if (op_brk)   kind = K_BRK;
    else if (nmi_pend) kind = K_NMI;
    else               kind = K_IRQ;
  end

  // R5: a masked level request never wins
  always_comb begin
    if (start === 1'b1)
      assert_irq_mask_R5: assert (!(kind == K_IRQ && i_flag));
  end
endmodule

// File: rtl/intseq_seq.sv
module intseq_seq
  import intseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  kind_e         kind,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] p_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          load_ctx,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] p_out,
  output logic [DW-1:0] sp_out,
  output logic          idle,
  output logic          busy
);
  state_e        state_q, state_nx;
  kind_e         kind_q, kind_nx;
  logic [DW-1:0] lo_q, pp_q;
  logic          lo_en, pp_en;
  logic [AW-1:0] vec_base;
  logic [DW-1:0] p_push;

  always_comb begin
    state_nx = state_q;
    kind_nx  = kind_q;
    unique case (state_q)
      S_BOOT:   state_nx = S_VEC_L;
      S_IDLE: if (start) begin
        kind_nx = kind;
        if (kind == K_RST)      state_nx = S_VEC_L;
        else if (kind == K_RTI) state_nx = S_PULL_P;
        else                    state_nx = S_PUSH_H;
      end
      S_PUSH_H: state_nx = S_PUSH_L;
      S_PUSH_L: state_nx = S_PUSH_P;
      S_PUSH_P: state_nx = S_VEC_L;
      S_VEC_L:  state_nx = S_VEC_H;
      S_VEC_H:  state_nx = S_IDLE;
      S_PULL_P: state_nx = S_PULL_L;
      S_PULL_L: state_nx = S_PULL_H;
      S_PULL_H: state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_comb begin
    lo_en = (state_q == S_VEC_L) || (state_q == S_PULL_L);
    pp_en = (state_q == S_PULL_P);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_BOOT;
      kind_q  <= K_RST;
      lo_q    <= '0;
      pp_q    <= '0;
    end else begin
      state_q <= state_nx;
      kind_q  <= kind_nx;
      if (lo_en) lo_q <= mem_rdata;
      if (pp_en) pp_q <= mem_rdata;
    end
  end

  always_comb begin
    unique case (kind_q)
      K_RST:   vec_base = VEC_RST;
      K_NMI:   vec_base = VEC_NMI;
      default: vec_base = VEC_IRQ;
    endcase
    p_push        = p_in;
    p_push[U_POS] = 1'b1;
    p_push[B_POS] = (kind_q == K_BRK);
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    load_ctx  = 1'b0;
    pc_out    = '0;
    p_out     = '0;
    sp_out    = '0;
    unique case (state_q)
      S_PUSH_H: begin
        mem_addr = {STACK_PAGE, sp_in};
        mem_wdata = pc_in[AW-1:DW];
        mem_we = 1'b1;
      end
      S_PUSH_L: begin
        mem_addr = {STACK_PAGE, sp_in - DW'(1)};
        mem_wdata = pc_in[DW-1:0];
        mem_we = 1'b1;
      end
      S_PUSH_P: begin
        mem_addr = {STACK_PAGE, sp_in - DW'(2)};
        mem_wdata = p_push;
        mem_we = 1'b1;
      end
      S_VEC_L: begin
        mem_addr = vec_base;
        mem_re = 1'b1;
      end
      S_VEC_H: begin
        mem_addr = vec_base | AW'(1);
        mem_re = 1'b1;
        load_ctx = 1'b1;
        pc_out = {mem_rdata, lo_q};
        p_out = p_in;
        p_out[I_POS] = 1'b1;
        sp_out = (kind_q == K_RST) ? sp_in : sp_in - DW'(ENTRY_PUSHES);
      end
      S_PULL_P: begin
        mem_addr = {STACK_PAGE, sp_in + DW'(1)};
        mem_re = 1'b1;
      end
      S_PULL_L: begin
        mem_addr = {STACK_PAGE, sp_in + DW'(2)};
        mem_re = 1'b1;
      end
      S_PULL_H: begin
        mem_addr = {STACK_PAGE, sp_in + DW'(3)};
        mem_re = 1'b1;
        load_ctx = 1'b1;
        pc_out = {mem_rdata, lo_q};
        p_out = pp_q;
        sp_out = sp_in + DW'(3);
      end
      default: ;
    endcase
    idle = (state_q == S_IDLE);
    busy = ~idle;
  end

  // R2: reads and writes never share a cycle
  assert_bus_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2: every write lands in the stack page
  assert_stack_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[AW-1:DW] == STACK_PAGE);

  // R2: successive pushes walk downward by one
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - AW'(1));

  // R1: a reset sequence never writes
  assert_reset_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_RST && busy) |-> !mem_we);

  // R6: entries always leave interrupts disabled
  assert_iset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ctx && kind_q != K_RTI) |-> p_out[I_POS]);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import intseq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_end,
  input  logic          op_brk,
  input  logic          op_rti,
  input  logic          reset_req,
  input  logic          nmi_n,
  input  logic          irq_n,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] p_in,
  input  logic [DW-1:0] sp_in,
  output logic          load_ctx,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] p_out,
  output logic [DW-1:0] sp_out,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          busy
);
  logic  rst_m, rst_s;
  logic  nmi_pend, irq_lvl;
  logic  start, idle;
  kind_e kind;
  logic  nmi_ack, nmi_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  always_comb begin
    nmi_ack = start & (kind == K_NMI);
    nmi_clr = start & (kind == K_RST);
  end

  intseq_sampler u_samp (
    .clk(clk), .rst_n(rst_s), .nmi_n(nmi_n), .irq_n(irq_n),
    .nmi_ack(nmi_ack), .nmi_clr(nmi_clr),
    .nmi_pend(nmi_pend), .irq_lvl(irq_lvl)
  );

  intseq_arbiter u_arb (
    .idle(idle), .insn_end(insn_end), .reset_req(reset_req),
    .op_brk(op_brk), .op_rti(op_rti), .nmi_pend(nmi_pend),
    .irq_lvl(irq_lvl), .i_flag(p_in[I_POS]),
    .start(start), .kind(kind)
  );

  intseq_seq u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .kind(kind),
    .pc_in(pc_in), .p_in(p_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .load_ctx(load_ctx), .pc_out(pc_out),
    .p_out(p_out), .sp_out(sp_out), .idle(idle), .busy(busy)
  );
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic insn_end, op_brk, op_rti, reset_req, nmi_n, irq_n;
  logic [15:0] pc_m;
  logic [7:0]  p_m, sp_m;
  logic load_ctx, mem_we, mem_re, busy;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  p_out, sp_out, mem_wdata, mem_rdata;
  logic [7:0]  stk [0:255];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .op_brk(op_brk),
    .op_rti(op_rti), .reset_req(reset_req), .nmi_n(nmi_n), .irq_n(irq_n),
    .pc_in(pc_m), .p_in(p_m), .sp_in(sp_m), .load_ctx(load_ctx),
    .pc_out(pc_out), .p_out(p_out), .sp_out(sp_out), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_re(mem_re), .busy(busy)
  );

  function automatic logic [7:0] vec_byte(logic [15:0] a);
    case (a)
      16'hFFFB: return 8'h20;
      16'hFFFD: return 8'h10;
      16'hFFFF: return 8'h30;
      default:  return 8'h00;
    endcase
  endfunction

  assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vec_byte(mem_addr);

  always @(posedge clk) begin
    if (rst_n && mem_we) stk[mem_addr[7:0]] <= mem_wdata;
    if (rst_n && load_ctx) begin
      pc_m <= pc_out; p_m <= p_out; sp_m <= sp_out;
    end
  end

  typedef struct {
    int k; logic [15:0] a; logic [15:0] d; logic [7:0] p; logic [7:0] s; string tag;
  } ev_t;
  ev_t exq[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_ev(int k, logic [15:0] a, logic [15:0] d, logic [7:0] p, logic [7:0] s, string tag);
    ev_t e;
    e.k = k; e.a = a; e.d = d; e.p = p; e.s = s; e.tag = tag;
    exq.push_back(e);
  endtask

  // hardware or break entry: R2 pushes, R3 pushed status, R4 vector, R6 I set
  task automatic exp_entry(logic [15:0] pc, logic [7:0] p, logic [7:0] sp,
                           logic [15:0] vec, bit brk, string tag);
    logic [7:0] pp;
    pp = (p | 8'h20) & 8'hEF;
    if (brk) pp = pp | 8'h10;
    push_ev(0, {8'h01, sp}, {8'h00, pc[15:8]}, 0, 0, {tag, "/R2"});
    push_ev(0, {8'h01, sp - 8'd1}, {8'h00, pc[7:0]}, 0, 0, {tag, "/R2"});
    push_ev(0, {8'h01, sp - 8'd2}, {8'h00, pp}, 0, 0, {tag, "/R3"});
    push_ev(1, vec, 0, 0, 0, {tag, "/R4"});
    push_ev(1, vec + 16'd1, 0, 0, 0, {tag, "/R4"});
    push_ev(2, 0, {vec_byte(vec + 16'd1), vec_byte(vec)}, p | 8'h04, sp - 8'd3, {tag, "/R6"});
  endtask

  task automatic exp_reset(logic [7:0] p, logic [7:0] sp);
    push_ev(1, 16'hFFFC, 0, 0, 0, "R1");
    push_ev(1, 16'hFFFD, 0, 0, 0, "R1");
    push_ev(2, 0, 16'h1000, p | 8'h04, sp, "R1");
  endtask

  // monitor: compares observed bus and load events against the scoreboard
  task automatic cmp(int k, logic [15:0] a, logic [15:0] d, logic [7:0] p, logic [7:0] s);
    ev_t e;
    if (exq.size() == 0) begin
      check(1'b0, "R8", $sformatf("unexpected event kind %0d at", k), a, 0);
      return;
    end
    e = exq.pop_front();
    check(e.k == k, e.tag, "event kind", k, e.k);
    if (e.k == k) begin
      if (k == 0) check(a == e.a && d == e.d, e.tag, "write addr/data", {a, d}, {e.a, e.d});
      if (k == 1) check(a == e.a, e.tag, "read addr", a, e.a);
      if (k == 2) check(d == e.d && p == e.p && s == e.s, e.tag, "load pc/p/sp",
                        {d, p, s}, {e.d, e.p, e.s});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) cmp(0, mem_addr, {8'h00, mem_wdata}, 0, 0);
      if (mem_re) cmp(1, mem_addr, 0, 0, 0);
      if (load_ctx) cmp(2, 0, pc_out, p_out, sp_out);
    end
  end

  // driver: one instruction of len cycles, with request edges at chosen indices
  task automatic insn(int len, int irq_at, int nmi_at, bit brk, bit rti, bit rst);
    while (busy) @(posedge clk);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      insn_end  = (i == len - 1);
      op_brk    = brk && (i == len - 1);
      op_rti    = rti && (i == len - 1);
      reset_req = rst && (i == len - 1);
      if (i == irq_at) irq_n = 1'b0;
      if (i == nmi_at) nmi_n = 1'b0;
    end
    @(posedge clk); #1;
    insn_end = 0; op_brk = 0; op_rti = 0; reset_req = 0;
  endtask

  task automatic settle(string tag);
    repeat (8) @(posedge clk);
    #1;
    check(exq.size() == 0, tag, "pending expected events", exq.size(), 0);
    check(busy == 1'b0, tag, "busy after sequence", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; insn_end = 0; op_brk = 0; op_rti = 0; reset_req = 0;
    nmi_n = 1; irq_n = 1; pc_m = 16'h0000; p_m = 8'h20; sp_m = 8'hFF;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(posedge clk); #1;
    check(busy == 1'b1 && mem_we == 1'b0, "R11", "busy/we in reset", {busy, mem_we}, 2'b10);
    exp_reset(8'h20, 8'hFF);
    rst_n = 1;
    settle("R1");
    check(pc_m == 16'h1000 && sp_m == 8'hFF, "R1", "core after reset", {pc_m, sp_m}, 24'h1000FF);

    // R9 positive and R5: irq low in penultimate cycle, served at this end
    p_m = 8'h20; pc_m = 16'h1234;
    exp_entry(16'h1234, 8'h20, 8'hFF, 16'hFFFE, 0, "R9");
    insn(3, 1, -1, 0, 0, 0);
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    settle("R5");
    check(stk[8'hFD] == 8'h20, "R3", "pushed status", stk[8'hFD], 8'h20);

    // R5: masked request ignored while I set (p_m now 0x24)
    insn(2, 0, -1, 0, 0, 0);
    settle("R5");
    check(pc_m == 16'h3000, "R5", "pc unchanged when masked", pc_m, 16'h3000);
    irq_n = 1;

    // R7/R5: edge-triggered request served with I set
    exp_entry(16'h3000, 8'h24, 8'hFC, 16'hFFFA, 0, "R7");
    insn(2, -1, 0, 0, 0, 0);
    settle("R7");
    insn(2, -1, -1, 0, 0, 0);
    settle("R7");
    nmi_n = 1;

    // R3: break pushes status with bit 4 set
    p_m = 8'h20; pc_m = 16'h2002;
    exp_entry(16'h2002, 8'h20, 8'hF9, 16'hFFFE, 1, "R3");
    insn(2, -1, -1, 1, 0, 0);
    settle("R3");
    check(stk[8'hF7] == 8'h30, "R3", "break bit in stack", stk[8'hF7], 8'h30);

    // R10: return pulls status, low, high
    push_ev(1, 16'h01F7, 0, 0, 0, "R10");
    push_ev(1, 16'h01F8, 0, 0, 0, "R10");
    push_ev(1, 16'h01F9, 0, 0, 0, "R10");
    push_ev(2, 0, 16'h2002, 8'h30, 8'hF9, "R10");
    insn(2, -1, -1, 0, 1, 0);
    settle("R10");

    // R9 negative: irq only in the last cycle waits one instruction
    p_m = 8'h20; pc_m = 16'h4000;
    insn(3, 2, -1, 0, 0, 0);
    repeat (3) @(posedge clk); #1;
    check(busy == 1'b0 && exq.size() == 0, "R9", "deferred request not yet served", busy, 0);
    exp_entry(16'h4000, 8'h20, 8'hF9, 16'hFFFE, 0, "R9");
    insn(2, -1, -1, 0, 0, 0);
    settle("R9");
    irq_n = 1;

    // R8: NMI beats IRQ
    p_m = 8'h20; pc_m = 16'h5000;
    exp_entry(16'h5000, 8'h20, 8'hF6, 16'hFFFA, 0, "R8");
    insn(2, 0, 0, 0, 0, 0);
    settle("R8");
    irq_n = 1; nmi_n = 1;

    // R8: break runs first, pending NMI served at the next end
    p_m = 8'h20; pc_m = 16'h6000;
    exp_entry(16'h6000, 8'h20, 8'hF3, 16'hFFFE, 1, "R8");
    insn(2, -1, 0, 1, 0, 0);
    settle("R8");
    exp_entry(16'h3000, 8'h24, 8'hF0, 16'hFFFA, 0, "R8");
    insn(1, -1, -1, 0, 0, 0);
    settle("R8");
    nmi_n = 1;

    // R1/R8: reset request beats NMI and discards it
    exp_reset(8'h24, 8'hED);
    insn(2, -1, 0, 0, 0, 1);
    settle("R1");
    insn(2, -1, -1, 0, 0, 0);
    settle("R1");
    check(pc_m == 16'h1000 && sp_m == 8'hED, "R1", "core after warm reset", {pc_m, sp_m}, 24'h1000ED);
    nmi_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule